// File: doc/BRIEF.md
# Redundant Energy Frame Receiver

This block takes the beam energy broadcast on two redundant serial links, A and B, and turns it into one trusted 16-bit value for the rest of the chip. Each link carries 32-bit frames. The block recovers the bits from an oversampled line, finds the fixed header, checks the CRC and keeps the last accepted value. Each link has counters for accepted frames, CRC failures and missed frame periods.

The output follows link A whenever A is healthy and moves to link B when A stops delivering. When neither link has delivered an accepted frame within its timeout, the block drives the largest energy code and raises an error flag, so a broken link can never look like low energy. A stale flag shows that the selected link has not sent fresh data (a changed toggle bit) for a long interval. A per-link warning shows that the error rate over a fixed window is above a programmable limit. All intervals are parameters in clock cycles.

Top module: `energy_frame_rx`

## Requirements
- R1: Each line idles low and sends a frame of 32 bits, most significant bit first, each bit held for CLKS_PER_BIT cycles. A frame starts on the first high level after idle. Bits 31..24 are the header, bits 23..8 the energy, bit 7 the toggle, bits 6..4 padding, bits 3..0 the CRC. A frame with header 8'h90 and a correct CRC is accepted, and its energy becomes that link's held value.
- R2: The CRC is the zero-initialised CRC-4 with polynomial x^4+x+1 over bits 31..4, most significant bit first. A frame with a correct header and a wrong CRC increments that link's CRC error counter and leaves the held value unchanged.
- R3: A frame whose header is not 8'h90 is discarded: no counter moves and the held value is kept.
- R4: Each accepted frame increments that link's good-frame counter by exactly one.
- R5: When FRAME_TIMEOUT cycles pass on a link without an accepted frame, that link is marked lost and its lost-frame counter increments. The count repeats every further FRAME_TIMEOUT cycles. The next accepted frame clears the lost mark.
- R6: active_o is one-hot or zero (bit 0 = A, bit 1 = B). A is used whenever it is not lost, B only when A is lost, and energy_o shows the held value of the used link.
- R7: When both links are lost, including from reset until the first accepted frame, energy_o is 16'hFFFF, link_err_o is 1 and active_o is 0.
- R8: stale_o is 1 from reset, goes to 0 when the used link accepts a frame whose toggle differs from its previous accepted toggle (or is its first accepted frame), and goes back to 1 after ENERGY_TIMEOUT cycles without such a frame.
- R9: At the end of each WIN_CYCLES window, warn_o of a link becomes 1 if the number of CRC errors plus frame timeouts in that window is greater than warn_limit_i, and becomes 0 otherwise.
- R10: All counters stop at their all-ones value. A high clr_i sets all six counters to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of the six counters |
| warn_limit_i | input | CNT_W | Per-window error count above which a warning is raised |
| ser_a_i | input | 1 | Serial line of link A |
| ser_b_i | input | 1 | Serial line of link B |
| energy_o | output | 16 | Selected energy value, or 16'hFFFF on double failure |
| link_err_o | output | 1 | Both links lost |
| stale_o | output | 1 | No fresh energy for ENERGY_TIMEOUT cycles |
| active_o | output | 2 | Link in use: bit 0 = A, bit 1 = B |
| warn_o | output | 2 | Error-rate warning: bit 0 = A, bit 1 = B |
| good_cnt_a_o | output | CNT_W | Accepted frames on A |
| crc_cnt_a_o | output | CNT_W | CRC errors on A |
| lost_cnt_a_o | output | CNT_W | Frame timeouts on A |
| good_cnt_b_o | output | CNT_W | Accepted frames on B |
| crc_cnt_b_o | output | CNT_W | CRC errors on B |
| lost_cnt_b_o | output | CNT_W | Frame timeouts on B |

## Verification
The clock edge that samples the last CRC bit is followed by a decode register, then the per-link counters, which change two edges after that sample. energy_o, active_o, link_err_o and stale_o change three edges after it, and warn_o changes one edge after a window closes. The bench drives an eight-cycle idle gap after every frame and compares outputs only after that gap. It places each scenario that depends on a frame or energy timeout at least fifteen cycles away from the edge where the timeout fires. Window warnings are checked only after more than two full windows of steady stimulus, so the result does not depend on where the windows fall.

// File: rtl/efr_pkg.sv
package efr_pkg;

    localparam int unsigned FRAME_BITS = 32;
    localparam int unsigned ENERGY_W   = 16;
    localparam logic [7:0]  SYNC_HDR   = 8'h90;
    localparam logic [ENERGY_W-1:0] ENERGY_SAFE = '1;

    typedef enum logic [1:0] {
        RX_GAP,
        RX_HUNT,
        RX_RECV
    } rx_state_e;

    typedef struct packed {
        logic                done;
        logic                good;
        logic                crc_bad;
        logic [ENERGY_W-1:0] energy;
        logic                toggle;
    } frame_t;

    // serial CRC-4, x^4 + x + 1, zero start, MSB first
    function automatic logic [3:0] crc4_calc(input logic [27:0] data);
        logic [3:0] c;
        logic       fb;
        c = '0;
        for (int i = 27; i >= 0; i--) begin
            fb = c[3] ^ data[i];
            c  = {c[2:0], 1'b0};
            if (fb) c = c ^ 4'h3;
        end
        return c;
    endfunction

endpackage

// File: rtl/efr_bit_rx.sv
module efr_bit_rx
    import efr_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ser_i,
    output frame_t frame_o
);

    localparam int unsigned CW   = $clog2(CLKS_PER_BIT + 1);
    localparam int unsigned HALF = CLKS_PER_BIT / 2;

    typedef struct packed {
        rx_state_e              st;
        logic [1:0]             sync;
        logic [CW-1:0]          cnt;
        logic [4:0]             nbit;
        logic [FRAME_BITS-1:0]  sh;
        frame_t                 frm;
    } rx_t;

    rx_t q, d;

    always_comb begin
        logic                  line;
        logic [FRAME_BITS-1:0] nsh;
        logic                  hdr_ok;
        logic                  crc_ok;
        d = q;
        d.sync        = {q.sync[0], ser_i};
        d.frm.done    = 1'b0;
        d.frm.good    = 1'b0;
        d.frm.crc_bad = 1'b0;
        line   = q.sync[1];
        nsh    = {q.sh[FRAME_BITS-2:0], line};
        hdr_ok = (nsh[31:24] == SYNC_HDR);
        crc_ok = (crc4_calc(nsh[31:4]) == nsh[3:0]);
        case (q.st)
            RX_GAP: begin
                if (!line) d.st = RX_HUNT;
            end
            RX_HUNT: begin
                if (line) begin
                    d.st   = RX_RECV;
                    d.cnt  = CW'(HALF - 1);
                    d.nbit = '0;
                end
            end
            RX_RECV: begin
                if (q.cnt == '0) begin
                    d.sh  = nsh;
                    d.cnt = CW'(CLKS_PER_BIT - 1);
                    if (q.nbit == 5'd31) begin
                        d.st          = RX_GAP;
                        d.nbit        = '0;
                        d.frm.done    = 1'b1;
                        d.frm.good    = hdr_ok & crc_ok;
                        d.frm.crc_bad = hdr_ok & ~crc_ok;
                        d.frm.energy  = nsh[23:8];
                        d.frm.toggle  = nsh[7];
                    end else begin
                        d.nbit = q.nbit + 5'd1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = RX_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_GAP;
        end else begin
            q <= d;
        end
    end

    assign frame_o = q.frm;

endmodule

// File: rtl/efr_lane_mon.sv
module efr_lane_mon
    import efr_pkg::*;
#(
    parameter int unsigned FRAME_TIMEOUT = 1000,
    parameter int unsigned CNT_W         = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                win_end_i,
    input  logic [CNT_W-1:0]    warn_limit_i,
    input  frame_t              frame_i,
    output logic                ok_o,
    output logic                fresh_o,
    output logic                warn_o,
    output logic [ENERGY_W-1:0] energy_o,
    output logic [CNT_W-1:0]    good_cnt_o,
    output logic [CNT_W-1:0]    crc_cnt_o,
    output logic [CNT_W-1:0]    lost_cnt_o
);

    localparam int unsigned TW = $clog2(FRAME_TIMEOUT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]    good;
        logic [CNT_W-1:0]    crc;
        logic [CNT_W-1:0]    lost_cnt;
        logic [CNT_W-1:0]    win_err;
        logic [TW-1:0]       tmr;
        logic                lost;
        logic                warn;
        logic [ENERGY_W-1:0] energy;
        logic                toggle;
        logic                seen;
        logic                fresh;
    } mon_t;

    mon_t q, d;

    always_comb begin
        logic timeout;
        logic err_ev;
        d       = q;
        d.fresh = 1'b0;
        timeout = 1'b0;
        if (frame_i.good) begin
            d.tmr    = '0;
            d.lost   = 1'b0;
            d.energy = frame_i.energy;
            d.toggle = frame_i.toggle;
            d.seen   = 1'b1;
            d.fresh  = ~q.seen | (frame_i.toggle != q.toggle);
            if (q.good != '1) d.good = q.good + 1'b1;
        end else if (q.tmr == TW'(FRAME_TIMEOUT - 1)) begin
            d.tmr   = '0;
            d.lost  = 1'b1;
            timeout = 1'b1;
            if (q.lost_cnt != '1) d.lost_cnt = q.lost_cnt + 1'b1;
        end else begin
            d.tmr = q.tmr + 1'b1;
        end
        if (frame_i.crc_bad && q.crc != '1) d.crc = q.crc + 1'b1;

        err_ev = frame_i.crc_bad | timeout;
        if (win_end_i) begin
            d.warn    = (q.win_err > warn_limit_i);
            d.win_err = err_ev ? CNT_W'(1) : '0;
        end else if (err_ev && q.win_err != '1) begin
            d.win_err = q.win_err + 1'b1;
        end

        if (clr_i) begin
            d.good     = '0;
            d.crc      = '0;
            d.lost_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.lost <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ok_o       = ~q.lost;
    assign fresh_o    = q.fresh;
    assign warn_o     = q.warn;
    assign energy_o   = q.energy;
    assign good_cnt_o = q.good;
    assign crc_cnt_o  = q.crc;
    assign lost_cnt_o = q.lost_cnt;

endmodule

// File: rtl/energy_frame_rx.sv
module energy_frame_rx
    import efr_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT   = 400,
    parameter int unsigned FRAME_TIMEOUT  = 50000,
    parameter int unsigned ENERGY_TIMEOUT = 40000000,
    parameter int unsigned WIN_CYCLES     = 40000000,
    parameter int unsigned CNT_W          = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [CNT_W-1:0]    warn_limit_i,
    input  logic                ser_a_i,
    input  logic                ser_b_i,
    output logic [ENERGY_W-1:0] energy_o,
    output logic                link_err_o,
    output logic                stale_o,
    output logic [1:0]          active_o,
    output logic [1:0]          warn_o,
    output logic [CNT_W-1:0]    good_cnt_a_o,
    output logic [CNT_W-1:0]    crc_cnt_a_o,
    output logic [CNT_W-1:0]    lost_cnt_a_o,
    output logic [CNT_W-1:0]    good_cnt_b_o,
    output logic [CNT_W-1:0]    crc_cnt_b_o,
    output logic [CNT_W-1:0]    lost_cnt_b_o
);

    localparam int unsigned NLANE = 2;
    localparam int unsigned WW    = $clog2(WIN_CYCLES + 1);
    localparam int unsigned SW    = $clog2(ENERGY_TIMEOUT + 1);

    logic                ser    [NLANE];
    frame_t              frm    [NLANE];
    logic                ok     [NLANE];
    logic                fresh  [NLANE];
    logic                warn   [NLANE];
    logic [ENERGY_W-1:0] held   [NLANE];
    logic [CNT_W-1:0]    gcnt   [NLANE];
    logic [CNT_W-1:0]    ccnt   [NLANE];
    logic [CNT_W-1:0]    lcnt   [NLANE];
    logic                win_end;

    assign ser[0] = ser_a_i;
    assign ser[1] = ser_b_i;

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        efr_bit_rx #(
            .CLKS_PER_BIT (CLKS_PER_BIT)
        ) u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .ser_i   (ser[gi]),
            .frame_o (frm[gi])
        );

        efr_lane_mon #(
            .FRAME_TIMEOUT (FRAME_TIMEOUT),
            .CNT_W         (CNT_W)
        ) u_mon (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr_i        (clr_i),
            .win_end_i    (win_end),
            .warn_limit_i (warn_limit_i),
            .frame_i      (frm[gi]),
            .ok_o         (ok[gi]),
            .fresh_o      (fresh[gi]),
            .warn_o       (warn[gi]),
            .energy_o     (held[gi]),
            .good_cnt_o   (gcnt[gi]),
            .crc_cnt_o    (ccnt[gi]),
            .lost_cnt_o   (lcnt[gi])
        );
    end

    typedef struct packed {
        logic [WW-1:0]       win;
        logic [SW-1:0]       stm;
        logic [ENERGY_W-1:0] energy;
        logic                err;
        logic [1:0]          active;
    } top_t;

    top_t q, d;

    assign win_end = (q.win == WW'(WIN_CYCLES - 1));

    always_comb begin
        logic use_a;
        logic use_b;
        logic fresh_sel;
        d     = q;
        d.win = win_end ? '0 : q.win + 1'b1;

        use_a     = ok[0];
        use_b     = ~ok[0] & ok[1];
        fresh_sel = (use_a & fresh[0]) | (use_b & fresh[1]);

        d.active = {use_b, use_a};
        d.err    = ~(ok[0] | ok[1]);
        if (use_a)      d.energy = held[0];
        else if (use_b) d.energy = held[1];
        else            d.energy = ENERGY_SAFE;

        if (fresh_sel)                          d.stm = '0;
        else if (q.stm != SW'(ENERGY_TIMEOUT))  d.stm = q.stm + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.stm    <= SW'(ENERGY_TIMEOUT);
            q.energy <= ENERGY_SAFE;
            q.err    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign energy_o     = q.energy;
    assign link_err_o   = q.err;
    assign stale_o      = (q.stm == SW'(ENERGY_TIMEOUT));
    assign active_o     = q.active;
    assign warn_o       = {warn[1], warn[0]};
    assign good_cnt_a_o = gcnt[0];
    assign crc_cnt_a_o  = ccnt[0];
    assign lost_cnt_a_o = lcnt[0];
    assign good_cnt_b_o = gcnt[1];
    assign crc_cnt_b_o  = ccnt[1];
    assign lost_cnt_b_o = lcnt[1];

endmodule

// File: rtl/efr_checker.sv
module efr_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic [15:0]      energy_o,
    input logic             link_err_o,
    input logic [1:0]       active_o,
    input logic [CNT_W-1:0] good_cnt_a_o,
    input logic [CNT_W-1:0] crc_cnt_a_o,
    input logic [CNT_W-1:0] lost_cnt_a_o
);

    a_r7_safe_value: assert property (@(posedge clk) disable iff (!rst_n)
        link_err_o |-> (energy_o == 16'hFFFF && active_o == 2'b00));

    a_r6_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_o));

    a_r6_source_when_healthy: assert property (@(posedge clk) disable iff (!rst_n)
        !link_err_o |-> (active_o != 2'b00));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (good_cnt_a_o == '0 && crc_cnt_a_o == '0 && lost_cnt_a_o == '0));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (good_cnt_a_o == '1 && !clr_i) |=> good_cnt_a_o == '1);

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (good_cnt_a_o == $past(good_cnt_a_o) ||
                    good_cnt_a_o == $past(good_cnt_a_o) + CNT_W'(1)));

endmodule

bind energy_frame_rx efr_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .energy_o     (energy_o),
    .link_err_o   (link_err_o),
    .active_o     (active_o),
    .good_cnt_a_o (good_cnt_a_o),
    .crc_cnt_a_o  (crc_cnt_a_o),
    .lost_cnt_a_o (lost_cnt_a_o)
);

// File: tb/energy_frame_rx_test.sv
`timescale 1ns/1ps
module energy_frame_rx_test;

    localparam int CPB   = 4;
    localparam int FTO   = 300;
    localparam int ETO   = 2000;
    localparam int WIN   = 3000;
    localparam int CW    = 8;
    localparam int GAP   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic [CW-1:0] warn_limit_i = 8'd5;
    logic          ser_a_i = 1'b0;
    logic          ser_b_i = 1'b0;
    logic [15:0]   energy_o;
    logic          link_err_o, stale_o;
    logic [1:0]    active_o, warn_o;
    logic [CW-1:0] good_cnt_a_o, crc_cnt_a_o, lost_cnt_a_o;
    logic [CW-1:0] good_cnt_b_o, crc_cnt_b_o, lost_cnt_b_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    energy_frame_rx #(
        .CLKS_PER_BIT (CPB), .FRAME_TIMEOUT (FTO), .ENERGY_TIMEOUT (ETO),
        .WIN_CYCLES (WIN), .CNT_W (CW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .clr_i (clr_i), .warn_limit_i (warn_limit_i),
        .ser_a_i (ser_a_i), .ser_b_i (ser_b_i), .energy_o (energy_o),
        .link_err_o (link_err_o), .stale_o (stale_o), .active_o (active_o),
        .warn_o (warn_o), .good_cnt_a_o (good_cnt_a_o), .crc_cnt_a_o (crc_cnt_a_o),
        .lost_cnt_a_o (lost_cnt_a_o), .good_cnt_b_o (good_cnt_b_o),
        .crc_cnt_b_o (crc_cnt_b_o), .lost_cnt_b_o (lost_cnt_b_o)
    );

    typedef struct {
        logic [15:0] energy;
        logic        err;
        logic [1:0]  active;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // remainder of data * x^4 divided by x^4 + x + 1
    function automatic logic [3:0] ref_crc(input logic [27:0] d);
        logic [31:0] m;
        m = {d, 4'b0};
        for (int i = 31; i >= 4; i--)
            if (m[i]) m[i -: 5] = m[i -: 5] ^ 5'b10011;
        return m[3:0];
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] hdr, input logic [15:0] e,
                                       input logic tog, input bit bad_crc);
        logic [27:0] body;
        body = {hdr, e, tog, 3'b000};
        return {body, ref_crc(body) ^ (bad_crc ? 4'h5 : 4'h0)};
    endfunction

    task automatic send(input bit en_a, input logic [31:0] fa,
                        input bit en_b, input logic [31:0] fb);
        for (int i = 31; i >= 0; i--) begin
            ser_a_i = en_a ? fa[i] : 1'b0;
            ser_b_i = en_b ? fb[i] : 1'b0;
            repeat (CPB) @(negedge clk);
        end
        ser_a_i = 1'b0;
        ser_b_i = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic expect_out(input logic [15:0] e, input logic err,
                              input logic [1:0] act, input string req);
        exp_t x;
        x.energy = e; x.err = err; x.active = act; x.req = req;
        sb_q.push_back(x);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares at a falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t x;
                x = sb_q.pop_front();
                chk({x.req, " energy"}, 32'(energy_o), 32'(x.energy));
                chk({x.req, " link_err"}, 32'(link_err_o), 32'(x.err));
                chk({x.req, " active"}, 32'(active_o), 32'(x.active));
            end
        end
    end

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R7 fail-safe, R8 stale, counters zero
        chk("R7 reset energy", 32'(energy_o), 32'hFFFF);
        chk("R7 reset link_err", 32'(link_err_o), 1);
        chk("R8 reset stale", 32'(stale_o), 1);
        chk("R10 reset good_a", 32'(good_cnt_a_o), 0);
        chk("R9 reset warn", 32'(warn_o), 0);

        // R1 first good frames, A preferred (R6)
        send(1, mk(8'h90, 16'h1234, 1'b1, 0), 1, mk(8'h90, 16'h5678, 1'b1, 0));
        expect_out(16'h1234, 1'b0, 2'b01, "R1 R6 first frame");
        chk("R4 good_a", 32'(good_cnt_a_o), 1);
        chk("R4 good_b", 32'(good_cnt_b_o), 1);
        chk("R8 fresh clears stale", 32'(stale_o), 0);

        // R2 corrupted CRC on A
        send(1, mk(8'h90, 16'h1111, 1'b0, 1), 1, mk(8'h90, 16'h5678, 1'b0, 0));
        expect_out(16'h1234, 1'b0, 2'b01, "R2 crc error keeps value");
        chk("R2 crc_a", 32'(crc_cnt_a_o), 1);
        chk("R2 good_a unchanged", 32'(good_cnt_a_o), 1);

        // R3 wrong header on A
        send(1, mk(8'h91, 16'h2222, 1'b1, 0), 1, mk(8'h90, 16'h0AAA, 1'b1, 0));
        expect_out(16'h1234, 1'b0, 2'b01, "R3 bad header ignored");
        chk("R3 good_a", 32'(good_cnt_a_o), 1);
        chk("R3 crc_a", 32'(crc_cnt_a_o), 1);
        chk("R3 lost_a", 32'(lost_cnt_a_o), 0);

        // R5 A silent until timeout, R6 B takes over
        send(0, 32'h0, 1, mk(8'h90, 16'h0BBB, 1'b0, 0));
        expect_out(16'h0BBB, 1'b0, 2'b10, "R5 R6 switch to B");
        chk("R5 lost_a first", 32'(lost_cnt_a_o), 1);
        send(0, 32'h0, 1, mk(8'h90, 16'h0CCC, 1'b1, 0));
        expect_out(16'h0CCC, 1'b0, 2'b10, "R6 B follows");
        chk("R5 lost_a within period", 32'(lost_cnt_a_o), 1);
        chk("R5 lost_b", 32'(lost_cnt_b_o), 0);

        // R7 both links silent
        repeat (700) @(negedge clk);
        expect_out(16'hFFFF, 1'b1, 2'b00, "R7 both lost");

        // R8 staleness
        send(1, mk(8'h90, 16'h0100, 1'b0, 0), 1, mk(8'h90, 16'h0200, 1'b0, 0));
        expect_out(16'h0100, 1'b0, 2'b01, "R6 A recovers");
        chk("R8 fresh after recovery", 32'(stale_o), 0);
        for (int k = 0; k < 14; k++)
            send(1, mk(8'h90, 16'h0100, 1'b0, 0), 1, mk(8'h90, 16'h0200, 1'b0, 0));
        chk("R8 not yet stale", 32'(stale_o), 0);
        for (int k = 0; k < 2; k++)
            send(1, mk(8'h90, 16'h0100, 1'b0, 0), 1, mk(8'h90, 16'h0200, 1'b0, 0));
        chk("R8 stale after timeout", 32'(stale_o), 1);
        chk("R8 link still ok", 32'(link_err_o), 0);
        send(1, mk(8'h90, 16'h0101, 1'b1, 0), 1, mk(8'h90, 16'h0201, 1'b1, 0));
        expect_out(16'h0101, 1'b0, 2'b01, "R8 toggle frame");
        chk("R8 toggle clears stale", 32'(stale_o), 0);

        // R9 warning on A with low limit
        warn_limit_i = 8'd5;
        for (int k = 0; k < 46; k++)
            send(1, mk(8'h90, 16'h0500, 1'b0, 1), 1, mk(8'h90, 16'h0300, 1'b1, 0));
        expect_out(16'h0300, 1'b0, 2'b10, "R6 R9 B while A corrupt");
        chk("R9 warn A only", 32'(warn_o), 2'b01);
        warn_limit_i = 8'd100;
        for (int k = 0; k < 46; k++)
            send(1, mk(8'h90, 16'h0500, 1'b0, 1), 1, mk(8'h90, 16'h0300, 1'b1, 0));
        chk("R9 high limit no warn", 32'(warn_o), 2'b00);

        // R10 clear and saturation
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk("R10 clear good_a", 32'(good_cnt_a_o), 0);
        chk("R10 clear crc_a", 32'(crc_cnt_a_o), 0);
        chk("R10 clear good_b", 32'(good_cnt_b_o), 0);
        chk("R10 clear lost_b", 32'(lost_cnt_b_o), 0);
        for (int k = 0; k < 260; k++)
            send(1, mk(8'h90, 16'h0700, 1'b0, 0), 1, mk(8'h90, 16'h0800, 1'b0, 0));
        chk("R10 saturate good_a", 32'(good_cnt_a_o), 255);
        chk("R10 saturate good_b", 32'(good_cnt_b_o), 255);
        chk("R10 crc_a after clear", 32'(crc_cnt_a_o), 0);
        expect_out(16'h0700, 1'b0, 2'b01, "R1 R6 final");

        done = 1;
        report();
    end

endmodule